// File: doc/BRIEF.md
# Privilege Status Register with Banked Stack Pointer

This block holds a processor's 16-bit status word: a trace flag, a supervisor flag, a three-bit interrupt mask that selects one of eight levels, and five condition flags (extend, negative, zero, overflow, carry). The upper byte carries the system fields. The lower byte carries the condition flags. Six positions in the word have no function and always read as zero. Two write ports reach the register. The full-word port is honoured only while the supervisor flag is set. The condition-byte port is honoured in both privilege states.

The block also banks the architectural stack pointer. A single read and write port for A7 reaches one of two physical registers, and the current supervisor flag picks which one. When the privilege changes, the port shows the other register on the next cycle and no data moves between the two. From the privilege level and the kind of the current access, a combinational encoder produces the three-bit address-space code that goes out with each bus access. Instruction decode and flag computation lie outside this block and drive its write ports.

Top module: `priv_status_bank`

## Requirements
- R1: After reset the status word reads 16'h2700 (supervisor set, trace clear, mask 7, all condition flags clear) and `priv_viol` is low.
- R2: Bits 14, 12, 11, 7, 6 and 5 of `sr_rd` always read 0, whatever value is written to them.
- R3: In supervisor state, a full-word write loads bit 15 (trace), bit 13 (supervisor), bits 10:8 (mask) and bits 4:0 (X, N, Z, V, C, from high to low) from `sr_wr_data`. The new value is visible one cycle later.
- R4: A full-word write attempted in user state (bit 13 clear) leaves the word unchanged, and `priv_viol` is high for exactly the following cycle. `priv_viol` is low at every other time.
- R5: A condition-byte write loads bits 4:0 from `ccr_wr_data[4:0]` in either state. It leaves bits 15:8 unchanged and ignores `ccr_wr_data[7:5]`.
- R6: When both write ports fire in one cycle, an accepted full-word write supplies bits 15:8 and the condition-byte write supplies bits 4:0. In user state only the condition-byte part takes effect.
- R7: `sp_rd` returns the supervisor stack pointer while bit 13 is set and the user stack pointer while it is clear. It follows a change of bit 13 on the next cycle, and neither register is copied or altered by the switch. Stack pointers are not cleared by reset.
- R8: A stack write stores to the bank selected by bit 13 as it stands in the write cycle, even when a full-word write changes bit 13 in that same cycle. The other bank is left untouched.
- R9: `space_code` depends on `acc_kind` (2'b00 data, 2'b01 program, 2'b1x CPU space) and bit 13. It is 3'b001 for user data, 3'b010 for user program, 3'b101 for supervisor data, 3'b110 for supervisor program and 3'b111 for CPU space in either state. It never takes the values 000, 011 or 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_wr_en | input | 1 | Full-word write request |
| sr_wr_data | input | 16 | Full-word write value |
| ccr_wr_en | input | 1 | Condition-byte write request |
| ccr_wr_data | input | 8 | Condition-byte write value |
| sr_rd | output | 16 | Current status word |
| priv_viol | output | 1 | One-cycle pulse after a rejected full-word write |
| sp_wr_en | input | 1 | Write to the architectural A7 |
| sp_wr_data | input | SP_W | A7 write value |
| sp_rd | output | SP_W | Architectural A7 from the selected bank |
| acc_kind | input | 2 | Access kind: 00 data, 01 program, 1x CPU space |
| space_code | output | 3 | Address-space code for the access |

## Verification
Two functions can coincide: a full-word write and a condition-byte write can land in the same cycle, and so can a full-word write that clears the supervisor flag and a stack write. The bench drives both write ports together in supervisor state and again in user state. It then judges the merged word against the split stated in R6, and it checks that the violation pulse still fires for the rejected half. For the stack collision, the bench reads the user bank after the switch, then resets to bring the supervisor bank back into view, and confirms which register took the write.

// File: rtl/psb_pkg.sv
package psb_pkg;
   localparam int unsigned SR_W      = 16;
   localparam int unsigned T_BIT     = 15;
   localparam int unsigned S_BIT     = 13;
   localparam int unsigned MASK_LO   = 8;
   localparam int unsigned MASK_W    = 3;
   localparam int unsigned CC_W      = 5;
   localparam int unsigned CCR_IN_W  = 8;
   localparam int unsigned SPACE_W   = 3;
   localparam int unsigned KIND_W    = 2;

   localparam logic [SR_W-1:0] SR_DEFINED =
      (SR_W'(1) << T_BIT) | (SR_W'(1) << S_BIT) |
      (SR_W'((1 << MASK_W) - 1) << MASK_LO) | SR_W'((1 << CC_W) - 1);

   typedef enum logic [KIND_W-1:0] {
      KIND_DATA = 2'b00,
      KIND_PROG = 2'b01,
      KIND_CPU  = 2'b10,
      KIND_CPU2 = 2'b11
   } acc_kind_e;

   localparam logic [SPACE_W-1:0] SPACE_CPU = 3'b111;
endpackage

// File: rtl/psb_status_reg.sv
module psb_status_reg
   import psb_pkg::*;
#(
   parameter int unsigned RESET_MASK = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                full_we,
   input  logic [SR_W-1:0]     full_wd,
   input  logic                cc_we,
   input  logic [CCR_IN_W-1:0] cc_wd,
   output logic [SR_W-1:0]     sr_q,
   output logic                viol_o
);
   localparam logic [SR_W-1:0] RST_WORD =
      (SR_W'(1) << S_BIT) | (SR_W'(RESET_MASK) << MASK_LO);

   logic            take_full;
   logic [SR_W-1:0] nxt;

   assign take_full = full_we & sr_q[S_BIT];

   always_comb begin
      nxt = sr_q;
      if (take_full) nxt = full_wd;
      if (cc_we)     nxt[CC_W-1:0] = cc_wd[CC_W-1:0];
   end

   for (genvar b = 0; b < SR_W; b++) begin : g_bit
      if (SR_DEFINED[b]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q[b] <= RST_WORD[b];
            else        sr_q[b] <= nxt[b];
         end
      end else begin : g_hole
         assign sr_q[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) viol_o <= 1'b0;
      else        viol_o <= full_we & ~sr_q[S_BIT];
   end
endmodule

// File: rtl/psb_stack_bank.sv
module psb_stack_bank #(
   parameter int unsigned SP_W = 32
) (
   input  logic            clk,
   input  logic            super_i,
   input  logic            we,
   input  logic [SP_W-1:0] wd,
   output logic [SP_W-1:0] rd
);
   logic [SP_W-1:0] usr_sp;
   logic [SP_W-1:0] sup_sp;

   always_ff @(posedge clk) begin
      if (we && super_i)  sup_sp <= wd;
      if (we && !super_i) usr_sp <= wd;
   end

   assign rd = super_i ? sup_sp : usr_sp;
endmodule

// File: rtl/psb_space_enc.sv
module psb_space_enc
   import psb_pkg::*;
(
   input  logic              super_i,
   input  logic [KIND_W-1:0] kind,
   output logic [SPACE_W-1:0] code
);
   always_comb begin
      unique case (acc_kind_e'(kind))
         KIND_DATA:           code = {super_i, 2'b01};
         KIND_PROG:           code = {super_i, 2'b10};
         KIND_CPU, KIND_CPU2: code = SPACE_CPU;
         default:             code = SPACE_CPU;
      endcase
   end
endmodule

// File: rtl/priv_status_bank.sv
module priv_status_bank
   import psb_pkg::*;
#(
   parameter int unsigned SP_W       = 32,
   parameter int unsigned RESET_MASK = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sr_wr_en,
   input  logic [15:0]          sr_wr_data,
   input  logic                 ccr_wr_en,
   input  logic [7:0]           ccr_wr_data,
   output logic [15:0]          sr_rd,
   output logic                 priv_viol,
   input  logic                 sp_wr_en,
   input  logic [SP_W-1:0]      sp_wr_data,
   output logic [SP_W-1:0]      sp_rd,
   input  logic [1:0]           acc_kind,
   output logic [2:0]           space_code
);
   if (SP_W < 16 || SP_W > 64) begin : g_bad_spw
      $error("SP_W must lie in 16..64");
   end
   if (RESET_MASK >= (1 << MASK_W)) begin : g_bad_mask
      $error("RESET_MASK must fit the mask field");
   end

   logic super_q;

   psb_status_reg #(.RESET_MASK(RESET_MASK)) u_sr (
      .clk     (clk),
      .rst_n   (rst_n),
      .full_we (sr_wr_en),
      .full_wd (sr_wr_data),
      .cc_we   (ccr_wr_en),
      .cc_wd   (ccr_wr_data),
      .sr_q    (sr_rd),
      .viol_o  (priv_viol)
   );

   assign super_q = sr_rd[S_BIT];

   psb_stack_bank #(.SP_W(SP_W)) u_sp (
      .clk     (clk),
      .super_i (super_q),
      .we      (sp_wr_en),
      .wd      (sp_wr_data),
      .rd      (sp_rd)
   );

   psb_space_enc u_fc (
      .super_i (super_q),
      .kind    (acc_kind),
      .code    (space_code)
   );
endmodule

// File: rtl/psb_chk.sv
module psb_chk #(
   parameter int unsigned SP_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sr_wr_en,
   input logic [15:0]     sr_wr_data,
   input logic            ccr_wr_en,
   input logic [7:0]      ccr_wr_data,
   input logic [15:0]     sr_rd,
   input logic            priv_viol,
   input logic            sp_wr_en,
   input logic [SP_W-1:0] sp_wr_data,
   input logic [SP_W-1:0] sp_rd,
   input logic [1:0]      acc_kind,
   input logic [2:0]      space_code
);
   // R2
   holes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_rd & 16'h58E0) == 16'h0000);

   // R4
   user_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_en && !sr_rd[13]) |=> priv_viol);

   // R4
   viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      priv_viol |-> $past(sr_wr_en && !sr_rd[13]));

   // R4
   user_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_en && !sr_rd[13] && !ccr_wr_en) |=> $stable(sr_rd));

   // R5
   cc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ccr_wr_en |=> (sr_rd[4:0] == $past(ccr_wr_data[4:0])));

   // R5
   cc_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_wr_en && !sr_wr_en) |=> (sr_rd[15:8] == $past(sr_rd[15:8])));

   // R7
   sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sp_wr_en && !sr_wr_en && !ccr_wr_en) |=> $stable(sp_rd));

   // R9
   cpu_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_kind[1] |-> (space_code == 3'b111));

   // R9
   space_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_kind[1] |-> (space_code[2] == sr_rd[13]));

   // R9
   space_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (space_code != 3'b000) && (space_code != 3'b011) && (space_code != 3'b100));
endmodule

bind priv_status_bank psb_chk #(.SP_W(SP_W)) u_chk (.*);

// File: tb/sim_priv_status_bank.sv
`timescale 1ns/1ps
module sim_priv_status_bank;
   localparam int unsigned SP_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sr_wr_en = 1'b0;
   logic [15:0]     sr_wr_data = '0;
   logic            ccr_wr_en = 1'b0;
   logic [7:0]      ccr_wr_data = '0;
   logic [15:0]     sr_rd;
   logic            priv_viol;
   logic            sp_wr_en = 1'b0;
   logic [SP_W-1:0] sp_wr_data = '0;
   logic [SP_W-1:0] sp_rd;
   logic [1:0]      acc_kind = 2'b00;
   logic [2:0]      space_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   priv_status_bank #(.SP_W(SP_W)) u0 (.*);

   // {sr_we, sr_wd, cc_we, cc_wd, exp_sr, exp_viol}
   localparam int NV = 8;
   localparam logic [42:0] VEC [NV] = '{
      {1'b1, 16'hFFFF, 1'b0, 8'h00, 16'hA71F, 1'b0},  // R3 R2 full write, holes dropped
      {1'b0, 16'h0000, 1'b1, 8'hE0, 16'hA700, 1'b0},  // R5 upper ccr bits ignored
      {1'b1, 16'h2300, 1'b1, 8'h15, 16'h2315, 1'b0},  // R6 merged write
      {1'b1, 16'h0005, 1'b0, 8'h00, 16'h0005, 1'b0},  // R3 drop to user
      {1'b1, 16'h2700, 1'b0, 8'h00, 16'h0005, 1'b1},  // R4 rejected
      {1'b0, 16'h0000, 1'b1, 8'h0A, 16'h000A, 1'b0},  // R5 user ccr write
      {1'b1, 16'hFFFF, 1'b1, 8'h11, 16'h0011, 1'b1},  // R6 R4 user merged
      {1'b0, 16'h0000, 1'b0, 8'h00, 16'h0011, 1'b0}   // R4 pulse ends
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 sr", 32'(sr_rd), 32'h2700);
      chk("R1 viol", 32'(priv_viol), 32'h0);

      for (int i = 0; i < NV; i++) begin
         sr_wr_en    = VEC[i][42];
         sr_wr_data  = VEC[i][41:26];
         ccr_wr_en   = VEC[i][25];
         ccr_wr_data = VEC[i][24:17];
         step();
         sr_wr_en  = 1'b0;
         ccr_wr_en = 1'b0;
         chk($sformatf("R3-6 vec%0d sr", i), 32'(sr_rd), 32'(VEC[i][16:1]));
         chk($sformatf("R4 vec%0d viol", i), 32'(priv_viol), 32'(VEC[i][0]));
      end
      // R2 holes read zero after writing all ones earlier and now
      chk("R2 holes", 32'(sr_rd & 16'h58E0), 32'h0);

      // R7 banking
      do_reset();
      sp_wr_en = 1'b1; sp_wr_data = 32'h0000_1000;
      step();
      sp_wr_en = 1'b0;
      chk("R7 super bank", sp_rd, 32'h0000_1000);
      sr_wr_en = 1'b1; sr_wr_data = 16'h0000;
      step();
      sr_wr_en = 1'b0;
      sp_wr_en = 1'b1; sp_wr_data = 32'h0000_2000;
      step();
      sp_wr_en = 1'b0;
      chk("R7 user bank", sp_rd, 32'h0000_2000);
      do_reset();
      chk("R7 super kept", sp_rd, 32'h0000_1000);

      // R8 stack write in the same cycle as a privilege drop
      sr_wr_en = 1'b1; sr_wr_data = 16'h0000;
      sp_wr_en = 1'b1; sp_wr_data = 32'h0000_3000;
      step();
      sr_wr_en = 1'b0; sp_wr_en = 1'b0;
      chk("R8 user untouched", sp_rd, 32'h0000_2000);

      // R9 user codes
      acc_kind = 2'b00; #1 chk("R9 user data", 32'(space_code), 32'h1);
      acc_kind = 2'b01; #1 chk("R9 user prog", 32'(space_code), 32'h2);
      acc_kind = 2'b10; #1 chk("R9 user cpu", 32'(space_code), 32'h7);
      acc_kind = 2'b11; #1 chk("R9 user cpu alt", 32'(space_code), 32'h7);
      acc_kind = 2'b00;
      do_reset();
      chk("R8 super took write", sp_rd, 32'h0000_3000);
      acc_kind = 2'b00; #1 chk("R9 super data", 32'(space_code), 32'h5);
      acc_kind = 2'b01; #1 chk("R9 super prog", 32'(space_code), 32'h6);
      acc_kind = 2'b10; #1 chk("R9 super cpu", 32'(space_code), 32'h7);
      acc_kind = 2'b00;

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule